// File: doc/BRIEF.md
# Transmit Buffer Status Controller

This block tells a host when it may safely begin loading a new frame into the transmit buffer. The buffer can be used as a single buffer or as two halves used in turn. In packet mode the buffer is a single slot. The buffer-empty flag goes high only when the frame in flight completes. In streaming mode the two halves alternate. The host fills one half while the other is sent. The buffer-empty flag rises as soon as a half the host can write into is free, even though a transmission is still running. A host write into a half that has not finished sending sets a sticky overflow flag.

The host writes bytes with `host_wr_i`. It commits the frame it has loaded by setting the start bit through `start_set_i`. The PHY side reports the end of each frame on `tx_done_i`. The block also holds the transmit data-rate code and flags the reserved codes. Every output is registered or decoded from a register, so each change appears one clock after the input that causes it.

Top module: `txbuf_status_ctrl`

## Requirements
- R1: After reset, `buf_empty_o`=1, `tx_busy_o`=0, `tx_irq_o`=0, `ovf_irq_o`=0, `rate_o`=3'b011, and `wr_buf_o`=`tx_buf_o`=0.
- R2: A host byte write clears `buf_empty_o` on the next clock in every mode. Writes are never refused. If a write and an event that would set the flag occur in the same cycle, the write wins and the flag reads 0.
- R3: A `start_set_i` pulse commits the half the host is filling if that half is free. `tx_busy_o` then reads 1 on the next clock, taking the block from idle to transmit. A start request while that half is still in use is ignored.
- R4: In packet mode (`mode_i` 00, 01 or 11), a `tx_done_i` pulse while busy does three things on the same next clock: `tx_busy_o` goes to 0, `buf_empty_o` goes to 1, and `tx_irq_o` pulses high for exactly one cycle. A `tx_done_i` pulse while idle has no effect.
- R5: In streaming mode (`mode_i`=10), each accepted commit toggles `wr_buf_o` between 0 and 1. `buf_empty_o` rises on the same clock if the half now selected is free. It stays 0 if that half is still loaded.
- R6: In streaming mode, a `tx_done_i` pulse frees the half being sent. On the next clock it sets `buf_empty_o`, pulses `tx_irq_o` and toggles `tx_buf_o`. `tx_busy_o` stays 1 while the other half holds a committed frame.
- R7: In streaming mode, a host write while the half selected by `wr_buf_o` is still committed or sending sets `ovf_irq_o` on the next clock. Writes into a free half never set it, and packet mode never sets it.
- R8: `ovf_irq_o` stays 1 until a cycle with `ovf_clr_i`=1 clears it on the next clock. If an overflow is detected in that same cycle, the flag stays 1.
- R9: `rate_wr_i` loads `rate_i` into `rate_o` on the next clock. Codes 3'b110 (2 Mbps), 3'b101 (1 Mbps), 3'b100 (500 kbps), 3'b011 (250 kbps) and 3'b010 (125 kbps) give `rate_invalid_o`=0. Codes 3'b111, 3'b001 and 3'b000 give `rate_invalid_o`=1.
- R10: In packet mode the block uses only half 0. After any idle packet-mode cycle, `wr_buf_o` and `tx_buf_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 10 = streaming (two halves), any other code = packet |
| host_wr_i | input | 1 | Host writes one byte into the buffer |
| start_set_i | input | 1 | Host sets the start-transmit bit (commits the loaded half) |
| tx_done_i | input | 1 | PHY side reports the current frame finished |
| ovf_clr_i | input | 1 | Host writes 1 to clear the overflow flag |
| rate_wr_i | input | 1 | Load strobe for the data-rate field |
| rate_i | input | 3 | Data-rate code to load |
| buf_empty_o | output | 1 | Host may start loading a new frame |
| tx_busy_o | output | 1 | Start-transmit bit: at least one committed frame is outstanding |
| tx_irq_o | output | 1 | One-cycle transmit-complete interrupt |
| ovf_irq_o | output | 1 | Sticky transmit-overflow interrupt flag |
| wr_buf_o | output | 1 | Half the host is currently filling |
| tx_buf_o | output | 1 | Half being sent, or the next one to be sent |
| rate_o | output | 3 | Registered data-rate code |
| rate_invalid_o | output | 1 | Registered code is reserved |

## Verification
The bound checker watches these rules on every cycle:
- a write clears the empty flag;
- each interrupt traces back to a completion of a busy frame;
- an overflow only rises from a streaming-mode write;
- the overflow flag holds until it is cleared;
- a start from idle always makes the block busy;
- packet-mode completion updates all three flags together;
- the rate-invalid decode matches the reserved codes.

Some behaviour needs a directed sequence. Only the bench's scenarios show the ping-pong order of the two halves, the empty flag staying low after a commit when the other half is still loaded, and an ignored start request. The same holds for write priority against a completion, and for an overflow that beats a clear in the same cycle.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam logic [1:0] MODE_STREAM = 2'b10;

  localparam logic [2:0] RATE_2M   = 3'b110;
  localparam logic [2:0] RATE_1M   = 3'b101;
  localparam logic [2:0] RATE_500K = 3'b100;
  localparam logic [2:0] RATE_250K = 3'b011;
  localparam logic [2:0] RATE_125K = 3'b010;
  localparam logic [2:0] RATE_RST  = RATE_250K;

  function automatic logic is_stream(input logic [1:0] mode);
    return mode == MODE_STREAM;
  endfunction

  function automatic logic rate_code_valid(input logic [2:0] code);
    case (code)
      RATE_2M, RATE_1M, RATE_500K, RATE_250K, RATE_125K: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/txbuf_slots.sv
module txbuf_slots #(
  parameter int NUM_BUF = 2,
  localparam int PTR_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stream_i,
  input  logic             commit_req_i,
  input  logic             done_i,
  output logic [NUM_BUF-1:0] busy_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] tx_ptr_o,
  output logic             commit_o,
  output logic             release_o,
  output logic             wr_slot_busy_o,
  output logic             next_free_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_BUF - 1);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  logic [NUM_BUF-1:0] busy_q;
  logic [PTR_W-1:0]   wr_ptr_q, tx_ptr_q;

  assign commit_o       = commit_req_i & ~busy_q[wr_ptr_q];
  assign release_o      = done_i & busy_q[tx_ptr_q];
  assign wr_slot_busy_o = busy_q[wr_ptr_q];
  assign next_free_o    = ~busy_q[nxt(wr_ptr_q)];

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
    logic set_s, clr_s;
    assign set_s = commit_o  && (wr_ptr_q == PTR_W'(i));
    assign clr_s = release_o && (tx_ptr_q == PTR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    busy_q[i] <= 1'b0;
      else if (set_s) busy_q[i] <= 1'b1;
      else if (clr_s) busy_q[i] <= 1'b0;
    end
  end

  // packet mode parks both pointers on half 0 whenever idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      tx_ptr_q <= '0;
    end else if (!stream_i) begin
      if (busy_q == '0) begin
        wr_ptr_q <= '0;
        tx_ptr_q <= '0;
      end
    end else begin
      if (commit_o)  wr_ptr_q <= nxt(wr_ptr_q);
      if (release_o) tx_ptr_q <= nxt(tx_ptr_q);
    end
  end

  assign busy_o   = busy_q;
  assign wr_ptr_o = wr_ptr_q;
  assign tx_ptr_o = tx_ptr_q;
endmodule

// File: rtl/txbuf_flags.sv
module txbuf_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stream_i,
  input  logic host_wr_i,
  input  logic commit_i,
  input  logic next_free_i,
  input  logic release_i,
  input  logic wr_slot_busy_i,
  input  logic ovf_clr_i,
  output logic empty_o,
  output logic irq_o,
  output logic ovf_o
);
  logic empty_q, irq_q, ovf_q;
  logic ovf_hit;

  assign ovf_hit = stream_i & host_wr_i & wr_slot_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      irq_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      irq_q <= release_i;
      if (host_wr_i)                                empty_q <= 1'b0;
      else if (release_i)                           empty_q <= 1'b1;
      else if (stream_i && commit_i && next_free_i) empty_q <= 1'b1;
      if (ovf_hit)        ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign empty_o = empty_q;
  assign irq_o   = irq_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/txbuf_rate.sv
module txbuf_rate
  import txbuf_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [RATE_W-1:0] code_i,
  output logic [RATE_W-1:0] code_o,
  output logic              invalid_o
);
  logic [RATE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= RATE_W'(RATE_RST);
    else if (wr_i) code_q <= code_i;
  end

  assign code_o    = code_q;
  assign invalid_o = ~rate_code_valid(3'(code_q));
endmodule

// File: rtl/txbuf_status_ctrl.sv
module txbuf_status_ctrl
  import txbuf_pkg::*;
#(
  parameter int NUM_BUF = 2,
  parameter int RATE_W  = 3,
  localparam int PTR_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              host_wr_i,
  input  logic              start_set_i,
  input  logic              tx_done_i,
  input  logic              ovf_clr_i,
  input  logic              rate_wr_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              buf_empty_o,
  output logic              tx_busy_o,
  output logic              tx_irq_o,
  output logic              ovf_irq_o,
  output logic [PTR_W-1:0]  wr_buf_o,
  output logic [PTR_W-1:0]  tx_buf_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              rate_invalid_o
);
  logic               stream;
  logic [NUM_BUF-1:0] busy;
  logic               commit, release_ev, wr_slot_busy, next_free;

  assign stream = is_stream(mode_i);

  txbuf_slots #(.NUM_BUF(NUM_BUF)) u_slots (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .stream_i       (stream),
    .commit_req_i   (start_set_i),
    .done_i         (tx_done_i),
    .busy_o         (busy),
    .wr_ptr_o       (wr_buf_o),
    .tx_ptr_o       (tx_buf_o),
    .commit_o       (commit),
    .release_o      (release_ev),
    .wr_slot_busy_o (wr_slot_busy),
    .next_free_o    (next_free)
  );

  txbuf_flags u_flags (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .stream_i       (stream),
    .host_wr_i      (host_wr_i),
    .commit_i       (commit),
    .next_free_i    (next_free),
    .release_i      (release_ev),
    .wr_slot_busy_i (wr_slot_busy),
    .ovf_clr_i      (ovf_clr_i),
    .empty_o        (buf_empty_o),
    .irq_o          (tx_irq_o),
    .ovf_o          (ovf_irq_o)
  );

  txbuf_rate #(.RATE_W(RATE_W)) u_rate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (rate_wr_i),
    .code_i    (rate_i),
    .code_o    (rate_o),
    .invalid_o (rate_invalid_o)
  );

  assign tx_busy_o = |busy;
endmodule

// File: rtl/txbuf_status_ctrl_chk.sv
module txbuf_status_ctrl_chk #(
  parameter int PTR_W  = 1,
  parameter int RATE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              host_wr_i,
  input logic              start_set_i,
  input logic              tx_done_i,
  input logic              ovf_clr_i,
  input logic              buf_empty_o,
  input logic              tx_busy_o,
  input logic              tx_irq_o,
  input logic              ovf_irq_o,
  input logic [PTR_W-1:0]  wr_buf_o,
  input logic [RATE_W-1:0] rate_o,
  input logic              rate_invalid_o
);
  p_wr_clears_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i |=> !buf_empty_o);

  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_set_i && !tx_busy_o) |=> tx_busy_o);

  p_pkt_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b10 && tx_done_i && tx_busy_o && !host_wr_i)
      |=> (buf_empty_o && !tx_busy_o && tx_irq_o));

  p_irq_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> $past(tx_done_i && tx_busy_o));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_irq_o) |-> $past(mode_i == 2'b10 && host_wr_i));

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_irq_o && !ovf_clr_i) |=> ovf_irq_o);

  p_rate_reserved_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_invalid_o == (rate_o == RATE_W'(7) || rate_o == RATE_W'(1) || rate_o == RATE_W'(0)));

  p_pkt_half0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b10 && !tx_busy_o) |=> (wr_buf_o == '0 || mode_i == 2'b10));
endmodule

bind txbuf_status_ctrl txbuf_status_ctrl_chk #(.PTR_W(PTR_W), .RATE_W(RATE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_i         (mode_i),
  .host_wr_i      (host_wr_i),
  .start_set_i    (start_set_i),
  .tx_done_i      (tx_done_i),
  .ovf_clr_i      (ovf_clr_i),
  .buf_empty_o    (buf_empty_o),
  .tx_busy_o      (tx_busy_o),
  .tx_irq_o       (tx_irq_o),
  .ovf_irq_o      (ovf_irq_o),
  .wr_buf_o       (wr_buf_o),
  .rate_o         (rate_o),
  .rate_invalid_o (rate_invalid_o)
);

// File: tb/txbuf_status_ctrl_tb.sv
module txbuf_status_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       host_wr_i = 1'b0, start_set_i = 1'b0, tx_done_i = 1'b0;
  logic       ovf_clr_i = 1'b0, rate_wr_i = 1'b0;
  logic [2:0] rate_i = 3'b000;
  logic       buf_empty_o, tx_busy_o, tx_irq_o, ovf_irq_o, rate_invalid_o;
  logic [0:0] wr_buf_o, tx_buf_o;
  logic [2:0] rate_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  txbuf_status_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .host_wr_i(host_wr_i),
    .start_set_i(start_set_i), .tx_done_i(tx_done_i), .ovf_clr_i(ovf_clr_i),
    .rate_wr_i(rate_wr_i), .rate_i(rate_i), .buf_empty_o(buf_empty_o),
    .tx_busy_o(tx_busy_o), .tx_irq_o(tx_irq_o), .ovf_irq_o(ovf_irq_o),
    .wr_buf_o(wr_buf_o), .tx_buf_o(tx_buf_o), .rate_o(rate_o),
    .rate_invalid_o(rate_invalid_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock; inputs set before the call apply at this edge and drop afterwards
  task automatic tick();
    @(posedge clk_i);
    #2;
    host_wr_i = 0; start_set_i = 0; tx_done_i = 0; ovf_clr_i = 0; rate_wr_i = 0;
  endtask

  task automatic t_reset();
    chk("R1", "empty", buf_empty_o, 1);
    chk("R1", "busy", tx_busy_o, 0);
    chk("R1", "irq", tx_irq_o, 0);
    chk("R1", "ovf", ovf_irq_o, 0);
    chk("R1", "rate", rate_o, 3);
    chk("R1", "wr_buf", wr_buf_o, 0);
    chk("R1", "tx_buf", tx_buf_o, 0);
  endtask

  task automatic t_packet(input logic [1:0] m);
    mode_i = m; tick();
    host_wr_i = 1; tick();
    chk("R2", "empty after write", buf_empty_o, 0);
    host_wr_i = 1; tick();
    chk("R2", "second write accepted", buf_empty_o, 0);
    start_set_i = 1; tick();
    chk("R3", "busy after start", tx_busy_o, 1);
    chk("R10", "wr_buf packet", wr_buf_o, 0);
    host_wr_i = 1; tick();
    chk("R7", "no ovf in packet", ovf_irq_o, 0);
    tx_done_i = 1; tick();
    chk("R4", "busy cleared", tx_busy_o, 0);
    chk("R4", "empty set", buf_empty_o, 1);
    chk("R4", "irq pulse", tx_irq_o, 1);
    tick();
    chk("R4", "irq one cycle", tx_irq_o, 0);
    tx_done_i = 1; tick();
    chk("R4", "idle done no irq", tx_irq_o, 0);
    chk("R4", "idle done busy", tx_busy_o, 0);
    chk("R10", "tx_buf packet", tx_buf_o, 0);
  endtask

  task automatic t_write_wins();
    mode_i = 2'b00;
    host_wr_i = 1; tick();
    start_set_i = 1; tick();
    host_wr_i = 1; tx_done_i = 1; tick();
    chk("R2", "write beats completion", buf_empty_o, 0);
    chk("R4", "busy cleared w/ write", tx_busy_o, 0);
    chk("R4", "irq w/ write", tx_irq_o, 1);
    tick();
  endtask

  task automatic t_stream();
    mode_i = 2'b10; tick();
    host_wr_i = 1; tick();
    chk("R2", "stream write clears", buf_empty_o, 0);
    start_set_i = 1; tick();
    chk("R3", "stream busy", tx_busy_o, 1);
    chk("R5", "wr_buf toggles to 1", wr_buf_o, 1);
    chk("R5", "empty set, half 1 free", buf_empty_o, 1);
    host_wr_i = 1; tick();
    chk("R7", "write into free half", ovf_irq_o, 0);
    start_set_i = 1; tick();
    chk("R5", "wr_buf back to 0", wr_buf_o, 0);
    chk("R5", "empty stays 0, half 0 loaded", buf_empty_o, 0);
    start_set_i = 1; tick();
    chk("R3", "start ignored when half busy", wr_buf_o, 0);
    host_wr_i = 1; tick();
    chk("R7", "overflow on busy half", ovf_irq_o, 1);
    tx_done_i = 1; tick();
    chk("R6", "irq on half free", tx_irq_o, 1);
    chk("R6", "empty set while sending", buf_empty_o, 1);
    chk("R6", "still busy", tx_busy_o, 1);
    chk("R6", "tx_buf to 1", tx_buf_o, 1);
    chk("R8", "ovf sticky", ovf_irq_o, 1);
    ovf_clr_i = 1; tick();
    chk("R8", "ovf cleared", ovf_irq_o, 0);
    host_wr_i = 1; tick();
    start_set_i = 1; tick();
    chk("R5", "wr_buf to 1", wr_buf_o, 1);
    chk("R5", "empty 0, half 1 sending", buf_empty_o, 0);
    host_wr_i = 1; ovf_clr_i = 1; tick();
    chk("R8", "set beats clear", ovf_irq_o, 1);
    tx_done_i = 1; tick();
    chk("R6", "tx_buf to 0", tx_buf_o, 0);
    chk("R6", "busy with half 0 loaded", tx_busy_o, 1);
    tx_done_i = 1; tick();
    chk("R6", "idle after both", tx_busy_o, 0);
    chk("R6", "tx_buf to 1 again", tx_buf_o, 1);
    ovf_clr_i = 1; tick();
    chk("R8", "ovf cleared again", ovf_irq_o, 0);
  endtask

  task automatic t_rate();
    for (int c = 0; c < 8; c++) begin
      rate_i = 3'(c); rate_wr_i = 1; tick();
      chk("R9", "rate code", rate_o, c);
      chk("R9", "rate invalid", rate_invalid_o, (c == 7 || c == 1 || c == 0) ? 1 : 0);
    end
    tick();
    chk("R9", "rate held", rate_o, 7);
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #13 rst_ni = 1'b1;
    #1 t_reset();
    t_packet(2'b00);
    t_packet(2'b11);
    t_packet(2'b01);
    t_write_wins();
    t_stream();
    t_rate();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule